// File: doc/BRIEF.md
# Live-Data Eye Scan Error Accumulator

This block estimates the bit error rate at one chosen offset point inside a receiver's data eye while the link keeps carrying traffic. Every cycle it receives a parallel word taken by the center sampler, which the clock recovery keeps in the middle of the eye, and a matching word taken by a second sampler that can be moved away from the center. Wherever the two words disagree, the moved sampler has made an error. The block counts those disagreements, and it also counts how many bits it has compared.

Control inputs choose the phase tap and the voltage tap of the moved sampler, a prescale that stretches the measurement, and a settle time. A start pulse clears both counters and freezes the offset outputs. The block waits for the settle time, then accumulates until the compared-bit counter reaches its full-scale value, and then raises done. The center-sampled words are passed downstream unchanged, one register later, whether or not a scan is running. Sweeping the taps and repeating the scan builds a two-dimensional error map of the eye.

Top module: `eyescan_accum`

## Requirements
- R1: `out_valid` and `out_data` equal `in_valid` and `in_center` from the previous clock cycle at all times after reset, whether or not a scan is running.
- R2: For every counted word, `err_count` grows by the number of bit positions where `in_center` and `in_offset` differ.
- R3: A word is counted only when `in_valid` is 1 while the block is counting. `samp_count` grows by W (16 by default) once for every 2^p counted words, where p is the `cfg_prescale` value captured at start.
- R4: `samp_count` and `err_count` saturate at 2^CW-1 (65535 by default) and never wrap.
- R5: Reset leaves both counters at 0 and `busy` and `done` at 0. A start pulse while idle clears both counters and raises `busy` on the next edge. When `samp_count` reaches 2^CW-1 the scan ends in that same cycle, `busy` falls and `done` rises. `done` then stays high until the next start. At prescale p the scan counts exactly 4096·2^p words.
- R6: After the start edge, no word is counted on the next `cfg_settle`+1 edges. Counting begins on the edge that follows.
- R7: `off_htap` and `off_vcode` follow the conditioned configuration one cycle later while the block is idle or done. While `busy` is 1 they hold the values captured at the start edge.
- R8: `off_htap` is a two's complement tap index centered on 0. `cfg_hrange` code n (0 to 3) sets a span of 64·2^n taps, and the index is clamped to the range -32·2^n to 32·2^n-1.
- R9: `off_vcode` is sign-magnitude: bit 7 is the sign (1 = below center) and bits 6:0 are the magnitude. A negative zero (0x80) is output as 0x00, and every other code passes through unchanged.
- R10: A start pulse while `busy` is 1 is ignored: the counters are not cleared and the scan goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word strobe for both sample streams |
| in_center | input | W | Word from the center sampler |
| in_offset | input | W | Word from the moved sampler |
| cfg_htap | input | HW | Requested phase tap, signed |
| cfg_hrange | input | 2 | Phase span code, span = 64·2^n taps |
| cfg_vcode | input | VW | Requested voltage tap, sign-magnitude |
| cfg_prescale | input | PW | Sample count scaling exponent |
| cfg_settle | input | SW | Settle cycles before counting |
| start | input | 1 | Scan start pulse |
| out_valid | output | 1 | Delayed copy of in_valid |
| out_data | output | W | Delayed copy of in_center |
| off_htap | output | HW | Phase tap applied to the moved sampler |
| off_vcode | output | VW | Voltage tap applied to the moved sampler |
| busy | output | 1 | Scan settling or counting |
| done | output | 1 | Scan finished, counts final |
| samp_count | output | CW | Compared-bit count |
| err_count | output | CW | Mismatching-bit count |

## Verification
Scans run with a fixed number of disagreeing bits per word. A small count shows the popcount path, and a full-word mismatch drives the error counter into saturation. A prescaled scan shows from its final error total whether the word-count scaling is right. Another scan leaves every other cycle without a strobe and makes those idle cycles fully mismatched, so any counting of idle words shows up in the error total. A further scan sends mismatching words only during the settle window and clean words after it, so a zero total is correct and an off-by-one in the settle timing gives a nonzero result. Separate idle-time cases at the range limits and at negative zero check the tap clamp and the voltage code handling, and a scoreboard compares every passed-through word.

// File: rtl/eyescan_pkg.sv
package eyescan_pkg;

    // Half span of the phase tap range at range code 0 (64 taps total).
    localparam int BASE_HALF_SPAN = 32;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_COUNT  = 2'd2,
        ST_DONE   = 2'd3
    } scan_state_e;

    // Command from the sequencer to the accumulators.
    typedef struct packed {
        logic clear;
        logic count;
    } scan_cmd_t;

    // Number of ones in a vector of up to 64 bits.
    function automatic int unsigned ones64(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/eyescan_offset.sv
module eyescan_offset
    import eyescan_pkg::*;
#(
    parameter int HW = 10,
    parameter int VW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic signed [HW-1:0] cfg_htap,
    input  logic [1:0]           cfg_hrange,
    input  logic [VW-1:0]        cfg_vcode,
    output logic signed [HW-1:0] off_htap,
    output logic [VW-1:0]        off_vcode
);
    localparam int HX = HW + 1;
    localparam logic [VW-1:0] NEG_ZERO = {1'b1, {(VW-1){1'b0}}};

    logic signed [HX-1:0] half_span;
    logic signed [HX-1:0] lo_lim;
    logic signed [HX-1:0] hi_lim;
    logic signed [HX-1:0] req_tap;
    logic signed [HX-1:0] clamped;
    logic [VW-1:0]        vnorm;

    always_comb begin
        half_span = $signed(HX'(BASE_HALF_SPAN) << cfg_hrange);
        lo_lim    = -half_span;
        hi_lim    = half_span - HX'(1);
        req_tap   = {cfg_htap[HW-1], cfg_htap};
        if (req_tap < lo_lim) begin
            clamped = lo_lim;
        end else if (req_tap > hi_lim) begin
            clamped = hi_lim;
        end else begin
            clamped = req_tap;
        end
        vnorm = (cfg_vcode == NEG_ZERO) ? '0 : cfg_vcode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_htap  <= '0;
            off_vcode <= '0;
        end else if (load) begin
            off_htap  <= clamped[HW-1:0];
            off_vcode <= vnorm;
        end
    end

endmodule

// File: rtl/eyescan_ctrl.sv
module eyescan_ctrl
    import eyescan_pkg::*;
#(
    parameter int PW = 3,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          in_valid,
    input  logic          finish,
    input  logic [SW-1:0] cfg_settle,
    input  logic [PW-1:0] cfg_prescale,
    output scan_cmd_t     cmd,
    output logic [PW-1:0] prescale_q,
    output logic          load_off,
    output logic          busy,
    output logic          done
);
    scan_state_e   state;
    logic [SW-1:0] settle_left;
    logic          idle_like;

    assign idle_like = (state == ST_IDLE) || (state == ST_DONE);
    assign load_off  = idle_like;
    assign busy      = (state == ST_SETTLE) || (state == ST_COUNT);
    assign done      = (state == ST_DONE);
    assign cmd.clear = start && idle_like;
    assign cmd.count = (state == ST_COUNT) && in_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            settle_left <= '0;
            prescale_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state       <= ST_SETTLE;
                        settle_left <= cfg_settle;
                        prescale_q  <= cfg_prescale;
                    end
                end
                ST_SETTLE: begin
                    if (settle_left == '0) begin
                        state <= ST_COUNT;
                    end else begin
                        settle_left <= settle_left - SW'(1);
                    end
                end
                ST_COUNT: begin
                    if (finish) begin
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eyescan_counters.sv
module eyescan_counters
    import eyescan_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 16,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  scan_cmd_t     cmd,
    input  logic [PW-1:0] prescale,
    input  logic [W-1:0]  center,
    input  logic [W-1:0]  offset,
    output logic [CW-1:0] samp,
    output logic [CW-1:0] err,
    output logic          finish
);
    localparam int PCW   = $clog2(W + 1);
    localparam int PRE_W = 1 << PW;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_last;
    logic             tick;
    logic [PCW-1:0]   word_errs;
    logic [CW:0]      samp_sum;
    logic [CW:0]      err_sum;
    logic [CW-1:0]    samp_next;
    logic [CW-1:0]    err_next;

    always_comb begin
        pre_last  = (PRE_W'(1) << prescale) - PRE_W'(1);
        tick      = cmd.count && (pre_cnt == pre_last);
        word_errs = PCW'(ones64(64'(center ^ offset)));
        samp_sum  = {1'b0, samp} + (CW+1)'(W);
        err_sum   = {1'b0, err} + (CW+1)'(word_errs);
        samp_next = samp_sum[CW] ? CMAX : samp_sum[CW-1:0];
        err_next  = err_sum[CW]  ? CMAX : err_sum[CW-1:0];
        finish    = tick && (samp_sum >= {1'b0, CMAX});
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            pre_cnt <= '0;
            samp    <= '0;
            err     <= '0;
        end else if (cmd.count) begin
            pre_cnt <= tick ? '0 : pre_cnt + PRE_W'(1);
            err     <= err_next;
            if (tick) begin
                samp <= samp_next;
            end
        end
    end

endmodule

// File: rtl/eyescan_accum.sv
module eyescan_accum
    import eyescan_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 16,
    parameter int HW = 10,
    parameter int VW = 8,
    parameter int PW = 3,
    parameter int SW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [W-1:0]         in_center,
    input  logic [W-1:0]         in_offset,
    input  logic signed [HW-1:0] cfg_htap,
    input  logic [1:0]           cfg_hrange,
    input  logic [VW-1:0]        cfg_vcode,
    input  logic [PW-1:0]        cfg_prescale,
    input  logic [SW-1:0]        cfg_settle,
    input  logic                 start,
    output logic                 out_valid,
    output logic [W-1:0]         out_data,
    output logic signed [HW-1:0] off_htap,
    output logic [VW-1:0]        off_vcode,
    output logic                 busy,
    output logic                 done,
    output logic [CW-1:0]        samp_count,
    output logic [CW-1:0]        err_count
);
    scan_cmd_t     cmd;
    logic [PW-1:0] prescale_q;
    logic          load_off;
    logic          finish;

    // Downstream path: a plain register stage, untouched by the scan.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= in_center;
        end
    end

    eyescan_ctrl #(.PW(PW), .SW(SW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .in_valid     (in_valid),
        .finish       (finish),
        .cfg_settle   (cfg_settle),
        .cfg_prescale (cfg_prescale),
        .cmd          (cmd),
        .prescale_q   (prescale_q),
        .load_off     (load_off),
        .busy         (busy),
        .done         (done)
    );

    eyescan_counters #(.W(W), .CW(CW), .PW(PW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .prescale (prescale_q),
        .center   (in_center),
        .offset   (in_offset),
        .samp     (samp_count),
        .err      (err_count),
        .finish   (finish)
    );

    eyescan_offset #(.HW(HW), .VW(VW)) u_off (
        .clk        (clk),
        .rst        (rst),
        .load       (load_off),
        .cfg_htap   (cfg_htap),
        .cfg_hrange (cfg_hrange),
        .cfg_vcode  (cfg_vcode),
        .off_htap   (off_htap),
        .off_vcode  (off_vcode)
    );

endmodule

// File: rtl/eyescan_accum_chk.sv
module eyescan_accum_chk
    import eyescan_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 16,
    parameter int HW = 10,
    parameter int VW = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [W-1:0]         in_center,
    input logic                 start,
    input logic                 out_valid,
    input logic [W-1:0]         out_data,
    input logic signed [HW-1:0] off_htap,
    input logic [VW-1:0]        off_vcode,
    input logic                 busy,
    input logic                 done,
    input logic [CW-1:0]        samp_count,
    input logic [CW-1:0]        err_count
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};
    localparam int HLIM = BASE_HALF_SPAN << 3;
    localparam logic [VW-1:0] NEG_ZERO = {1'b1, {(VW-1){1'b0}}};

    p_pass_valid_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    p_pass_data_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_data == $past(in_center)));

    p_samp_mono_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (samp_count >= $past(samp_count)));

    p_err_mono_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (err_count >= $past(err_count)));

    p_done_full_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (samp_count == CMAX));

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (samp_count == '0 && err_count == '0));

    p_offset_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(off_htap) && $stable(off_vcode)));

    p_hrange_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(off_htap) >= -HLIM) && (int'(off_htap) <= HLIM - 1));

    p_vcode_r9: assert property (@(posedge clk) disable iff (rst)
        off_vcode != NEG_ZERO);

endmodule

bind eyescan_accum eyescan_accum_chk #(.W(W), .CW(CW), .HW(HW), .VW(VW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_center  (in_center),
    .start      (start),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .off_htap   (off_htap),
    .off_vcode  (off_vcode),
    .busy       (busy),
    .done       (done),
    .samp_count (samp_count),
    .err_count  (err_count)
);

// File: tb/tb_eyescan_accum.sv
module tb_eyescan_accum;
    localparam int W  = 16;
    localparam int CW = 16;
    localparam int HW = 10;
    localparam int VW = 8;
    localparam int PW = 3;
    localparam int SW = 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [W-1:0]         in_center = '0;
    logic [W-1:0]         in_offset = '0;
    logic signed [HW-1:0] cfg_htap = '0;
    logic [1:0]           cfg_hrange = '0;
    logic [VW-1:0]        cfg_vcode = '0;
    logic [PW-1:0]        cfg_prescale = '0;
    logic [SW-1:0]        cfg_settle = '0;
    logic                 start = 1'b0;
    logic                 out_valid;
    logic [W-1:0]         out_data;
    logic signed [HW-1:0] off_htap;
    logic [VW-1:0]        off_vcode;
    logic                 busy;
    logic                 done;
    logic [CW-1:0]        samp_count;
    logic [CW-1:0]        err_count;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] lfsr = 16'hACE1;
    logic [W:0]   exp_q [$];

    eyescan_accum #(.W(W), .CW(CW), .HW(HW), .VW(VW), .PW(PW), .SW(SW)) dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mask_of(input int k);
        return (k >= W) ? {W{1'b1}} : W'((32'd1 << k) - 1);
    endfunction

    // Driver: sets one cycle of inputs and queues the expected passthrough.
    task automatic drive(input logic v, input logic [W-1:0] c, input logic [W-1:0] o, input logic st);
        @(negedge clk);
        in_valid  = v;
        in_center = c;
        in_offset = o;
        start     = st;
        exp_q.push_back({v, c});
    endtask

    task automatic idle();
        drive(1'b0, lfsr, lfsr, 1'b0);
    endtask

    function automatic logic [W-1:0] next_word();
        lfsr = {lfsr[W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr;
    endfunction

    // Monitor: checks the passthrough against the scoreboard (R1).
    always @(posedge clk) begin
        logic in_rst;
        logic [W:0] item;
        in_rst = rst;
        #1;
        if (exp_q.size() > 0) begin
            item = exp_q.pop_front();
            if (!in_rst) begin
                chk("R1 valid", 32'(out_valid), 32'(item[W]));
                chk("R1 data", 32'(out_data), 32'(item[W-1:0]));
            end
        end
    end

    // One scan: k mismatches per valid word; optional idle gaps full of
    // mismatches; the first bad_n words fully mismatched.
    task automatic scan(input string req, input int k, input bit gaps, input int bad_n,
                        input logic [31:0] exp_err, input bit restart_mid);
        int i;
        logic [W-1:0] c;
        logic [CW-1:0] samp_before;
        for (i = 0; i < 150000; i++) begin
            c = next_word();
            if (gaps && (i % 2 == 1)) begin
                drive(1'b0, c, ~c, 1'b0);
            end else if (i < bad_n) begin
                drive(1'b1, c, ~c, i == 0);
            end else begin
                drive(1'b1, c, c ^ mask_of(k), (i == 0) || (restart_mid && i == 300));
            end
            if (i == 1) begin
                chk("R5 busy after start", 32'(busy), 32'd1);
                chk("R5 cleared samp", 32'(samp_count), 32'd0);
                chk("R5 cleared err", 32'(err_count), 32'd0);
            end
            if (restart_mid && i == 200) begin
                cfg_htap  = 10'sd7;
                cfg_vcode = 8'h11;
            end
            if (restart_mid && i == 201) begin
                chk("R7 htap held", 32'(off_htap), 32'(10'sd3));
                chk("R7 vcode held", 32'(off_vcode), 32'h22);
            end
            if (restart_mid && i == 299) samp_before = samp_count;
            if (restart_mid && i == 302) begin
                chk("R10 still busy", 32'(busy), 32'd1);
                chk("R10 no clear", 32'(samp_count >= samp_before && samp_before != 0), 32'd1);
            end
            if (i >= 1 && done) break;
        end
        chk({req, " done"}, 32'(done), 32'd1);
        chk({req, " not busy"}, 32'(busy), 32'd0);
        chk({req, " samp full R4"}, 32'(samp_count), 32'hFFFF);
        chk({req, " err"}, 32'(err_count), exp_err);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        repeat (5) idle();
        rst = 1'b0;
        idle();
        chk("R5 reset busy", 32'(busy), 32'd0);
        chk("R5 reset done", 32'(done), 32'd0);
        chk("R5 reset samp", 32'(samp_count), 32'd0);
        chk("R5 reset err", 32'(err_count), 32'd0);

        // R8: clamp per range code.
        cfg_hrange = 2'd0; cfg_htap = 10'sd100; idle();
        chk("R8 range0 high clamp", 32'(off_htap), 32'(10'sd31));
        cfg_htap = -10'sd100; idle();
        chk("R8 range0 low clamp", 32'(off_htap), 32'(-10'sd32));
        cfg_hrange = 2'd3; cfg_htap = 10'sd300; idle();
        chk("R8 range3 high clamp", 32'(off_htap), 32'(10'sd255));
        cfg_htap = -10'sd300; idle();
        chk("R8 range3 low clamp", 32'(off_htap), 32'(-10'sd256));
        cfg_hrange = 2'd1; cfg_htap = -10'sd5; idle();
        chk("R8 in range", 32'(off_htap), 32'(-10'sd5));

        // R9: sign-magnitude voltage code.
        cfg_vcode = 8'h80; idle();
        chk("R9 negative zero", 32'(off_vcode), 32'h00);
        cfg_vcode = 8'h85; idle();
        chk("R9 negative code", 32'(off_vcode), 32'h85);
        cfg_vcode = 8'h05; idle();
        chk("R9 positive code", 32'(off_vcode), 32'h05);

        // R2/R5/R7/R10: 3 errors per word, 4096 words.
        cfg_htap = 10'sd3; cfg_vcode = 8'h22; cfg_prescale = 3'd0; cfg_settle = 8'd3;
        scan("R2 k3", 3, 1'b0, 0, 32'd12288, 1'b1);
        idle();
        chk("R7 htap follows after done", 32'(off_htap), 32'(10'sd7));
        chk("R7 vcode follows after done", 32'(off_vcode), 32'h11);
        chk("R5 done held", 32'(done), 32'd1);

        // R4: full-word mismatch saturates the error counter.
        scan("R4 k16", 16, 1'b0, 0, 32'hFFFF, 1'b0);

        // R3: prescale 2 means 16384 words, one error each.
        cfg_prescale = 3'd2;
        scan("R3 prescale2", 1, 1'b0, 0, 32'd16384, 1'b0);

        // R3: idle cycles carry mismatches and must not count.
        cfg_prescale = 3'd0;
        scan("R3 gaps", 2, 1'b1, 0, 32'd8192, 1'b0);

        // R6: mismatches only inside the settle window.
        cfg_settle = 8'd20;
        scan("R6 settle", 0, 1'b0, 22, 32'd0, 1'b0);

        repeat (3) idle();
        $display("  Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule